// File: doc/BRIEF.md
# Debug Serial Command Sequencer

This block decodes commands and steps through the transfer sequence for a background debug port. A serial transfer layer outside the block shifts each 16-bit host word in. It presents the word in parallel together with a one-cycle strobe. While that word arrives, the block's 17-bit response word (one status bit and 16 data bits) is shifted out to the host. A response therefore always belongs to the transfer that carries it: it answers the word received one transfer earlier.

A memory-read command carries a two-bit size field that selects a byte, word or longword access. Two further transfers supply the upper and then the lower half of the 32-bit address. Once the third word has arrived, the block issues one read on a request/acknowledge/error memory bus. Transfers that arrive during the access are answered with not-ready. The result comes back over the following transfers, and the next command's opcode arrives in the same transfer that returns the last result half. The block rejects an opcode it does not recognise and drops the operand word that follows it.

Top module: `dbg_cmd_seq`

## Requirements
- R1: After reset the response word is command-complete (status 1, data 0xFFFF) and no memory request is active.
- R2: A word received as a command is a legal read only when bits 15:8 equal 0xA5, bits 7:2 are zero and the size field in bits 1:0 is 00 (byte), 01 (word) or 10 (longword). Any other command word makes the response of the next transfer the illegal-command status (status 1, data 0xFFFF).
- R3: After an illegal command, the block discards the next received word, even a legal opcode. The transfer after that returns command-complete, and the word following the discarded one is decoded as a new command.
- R4: The two transfers after a legal opcode return not-ready (status 1, data 0x0000). They supply address bits 31:16 and then 15:0. In the cycle after the third word, memReq is high, memAddr carries the gathered address and memSize carries the size field.
- R5: memReq stays high with memAddr and memSize unchanged until memAck or memErr is sampled. It is low in the cycle that follows.
- R6: Every transfer received while the access is outstanding returns not-ready and has no effect on the address or the result.
- R7: A longword read returns memRdata bits 31:16 with status 0 in the first transfer after the access. The next transfer returns bits 15:0 with status 0, and the word received in that transfer is decoded as the next command.
- R8: A word read returns memRdata bits 15:0 with status 0, and a byte read returns memRdata bits 7:0 in data bits 7:0 with status 0. Either result comes in one transfer, and the word received in that transfer is the next command.
- R9: An access ended by memErr returns status 1 with data 0x0001 in one transfer instead of result data. The word received in that transfer is the next command.
- R10: The response to each transfer is in place in the clock cycle after that transfer's strobe, well inside 32 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wordValid | input | 1 | One-cycle strobe: a received host word is present |
| wordIn | input | 16 | Received host word |
| respWord | output | 17 | Response for the next transfer: bit 16 status, bits 15:0 data |
| memReq | output | 1 | Memory read request |
| memAddr | output | 32 | Read address |
| memSize | output | 2 | Access size: 0 byte, 1 word, 2 longword |
| memAck | input | 1 | Read completed, memRdata valid |
| memErr | input | 1 | Read terminated with a bus error |
| memRdata | input | 32 | Read data, byte in bits 7:0 and word in bits 15:0 |

## Verification
The assertions assume a memory that raises memAck or memErr only while memReq is high, never both at once, and each for exactly one cycle per request. They also assume wordValid is a single-cycle pulse. The bench responder keeps to these rules: it waits a programmed latency of zero to four cycles, gives exactly one termination for each request, and clears it on the next cycle. The host model strobes one word at a time with idle cycles between strobes. It sends poll words during an access only when the latency leaves room for them.

// File: rtl/dbg_cmd_seq_pkg.sv
package dbg_cmd_seq_pkg;

  // Access size codes, shared by the opcode size field and memSize
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;

  // Source of the next response word
  typedef enum logic [2:0] {
    RS_NOTREADY = 3'd0,
    RS_ILLEGAL  = 3'd1,
    RS_COMPLETE = 3'd2,
    RS_BERR     = 3'd3,
    RS_RDHI     = 3'd4,
    RS_RDWORD   = 3'd5,
    RS_RDBYTE   = 3'd6,
    RS_SAVEDLO  = 3'd7
  } respSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic     loadHi;
    logic     loadLo;
    logic     latchData;
    logic     respLoad;
    respSel_t respSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/dbg_cmd_seq_ctrl.sv
module dbg_cmd_seq_ctrl
  import dbg_cmd_seq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter logic [7:0] CMD_TAG = 8'hA5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wordValid,
  input  logic [WORD_W-1:0]   wordIn,
  input  logic                memAck,
  input  logic                memErr,
  output logic                memReq,
  output logic [1:0]          memSize,
  output ctrlStrobes_t        strobes
);

  localparam int MID_W = WORD_W - 10;

  typedef enum logic [2:0] {
    S_CMD, S_DISCARD, S_ADDRH, S_ADDRL, S_BUSY, S_RESHI
  } state_t;

  state_t     state, stateNext;
  logic [1:0] sizeReg, sizeNext;
  logic       legalOp;

  // Command decode: tag byte on top, zero middle bits, size not 11
  assign legalOp = (wordIn[WORD_W-1 -: 8] == CMD_TAG) &&
                   (wordIn[WORD_W-9:2] == MID_W'(0)) &&
                   (wordIn[1:0] != 2'b11);

  always_comb begin
    stateNext = state;
    sizeNext  = sizeReg;
    strobes   = '{loadHi: 1'b0, loadLo: 1'b0, latchData: 1'b0,
                  respLoad: 1'b0, respSel: RS_NOTREADY};
    unique case (state)
      S_CMD: if (wordValid) begin
        strobes.respLoad = 1'b1;
        if (legalOp) begin
          sizeNext        = wordIn[1:0];
          strobes.respSel = RS_NOTREADY;
          stateNext       = S_ADDRH;
        end else begin
          strobes.respSel = RS_ILLEGAL;
          stateNext       = S_DISCARD;
        end
      end
      S_DISCARD: if (wordValid) begin
        strobes.respLoad = 1'b1;
        strobes.respSel  = RS_COMPLETE;
        stateNext        = S_CMD;
      end
      S_ADDRH: if (wordValid) begin
        strobes.loadHi   = 1'b1;
        strobes.respLoad = 1'b1;
        strobes.respSel  = RS_NOTREADY;
        stateNext        = S_ADDRL;
      end
      S_ADDRL: if (wordValid) begin
        strobes.loadLo   = 1'b1;
        strobes.respLoad = 1'b1;
        strobes.respSel  = RS_NOTREADY;
        stateNext        = S_BUSY;
      end
      S_BUSY: begin
        // polls are ignored; response stays not-ready
        if (memErr) begin
          strobes.respLoad = 1'b1;
          strobes.respSel  = RS_BERR;
          stateNext        = S_CMD;
        end else if (memAck) begin
          strobes.respLoad = 1'b1;
          if (sizeReg == SZ_LONG) begin
            strobes.latchData = 1'b1;
            strobes.respSel   = RS_RDHI;
            stateNext         = S_RESHI;
          end else begin
            strobes.respSel = (sizeReg == SZ_WORD) ? RS_RDWORD : RS_RDBYTE;
            stateNext       = S_CMD;
          end
        end
      end
      S_RESHI: if (wordValid) begin
        strobes.respLoad = 1'b1;
        strobes.respSel  = RS_SAVEDLO;
        stateNext        = S_CMD;
      end
      default: stateNext = S_CMD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_CMD;
      sizeReg <= SZ_BYTE;
    end else begin
      state   <= stateNext;
      sizeReg <= sizeNext;
    end
  end

  assign memReq  = (state == S_BUSY);
  assign memSize = sizeReg;

  // R3: a discarded word is never taken as address
  a_r3_discard_no_addr: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DISCARD) |-> !strobes.loadHi && !strobes.loadLo);

  // R2: an illegal opcode never leads to an address phase
  a_r2_illegal_to_discard: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CMD && wordValid && !legalOp) |=> (state == S_DISCARD));

endmodule

// File: rtl/dbg_cmd_seq_dpath.sv
module dbg_cmd_seq_dpath
  import dbg_cmd_seq_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  input  logic [WORD_W-1:0]     wordIn,
  input  logic [2*WORD_W-1:0]   memRdata,
  output logic [2*WORD_W-1:0]   memAddr,
  output logic [WORD_W:0]       respWord
);

  localparam int DATA_W = 2 * WORD_W;
  localparam int RESP_W = WORD_W + 1;

  logic [WORD_W-1:0] addrHi, addrLo, savedLo;
  logic [RESP_W-1:0] respNext;

  always_comb begin
    unique case (strobes.respSel)
      RS_NOTREADY: respNext = {1'b1, {WORD_W{1'b0}}};
      RS_ILLEGAL:  respNext = {1'b1, {WORD_W{1'b1}}};
      RS_COMPLETE: respNext = {1'b1, {WORD_W{1'b1}}};
      RS_BERR:     respNext = {1'b1, WORD_W'(1)};
      RS_RDHI:     respNext = {1'b0, memRdata[DATA_W-1 -: WORD_W]};
      RS_RDWORD:   respNext = {1'b0, memRdata[WORD_W-1:0]};
      RS_RDBYTE:   respNext = {1'b0, {(WORD_W-8){1'b0}}, memRdata[7:0]};
      RS_SAVEDLO:  respNext = {1'b0, savedLo};
      default:     respNext = {1'b1, {WORD_W{1'b0}}};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHi   <= '0;
      addrLo   <= '0;
      savedLo  <= '0;
      respWord <= {1'b1, {WORD_W{1'b1}}};
    end else begin
      if (strobes.loadHi)    addrHi   <= wordIn;
      if (strobes.loadLo)    addrLo   <= wordIn;
      if (strobes.latchData) savedLo  <= memRdata[WORD_W-1:0];
      if (strobes.respLoad)  respWord <= respNext;
    end
  end

  assign memAddr = {addrHi, addrLo};

  // R10: the response register moves only on a control strobe
  a_r10_resp_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.respLoad |=> $stable(respWord));

endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
  import dbg_cmd_seq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter logic [7:0] CMD_TAG = 8'hA5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wordValid,
  input  logic [WORD_W-1:0]     wordIn,
  output logic [WORD_W:0]       respWord,
  output logic                  memReq,
  output logic [2*WORD_W-1:0]   memAddr,
  output logic [1:0]            memSize,
  input  logic                  memAck,
  input  logic                  memErr,
  input  logic [2*WORD_W-1:0]   memRdata
);

  ctrlStrobes_t strobes;

  dbg_cmd_seq_ctrl #(.WORD_W(WORD_W), .CMD_TAG(CMD_TAG)) uCtrl (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordIn(wordIn),
    .memAck(memAck), .memErr(memErr), .memReq(memReq),
    .memSize(memSize), .strobes(strobes)
  );

  dbg_cmd_seq_dpath #(.WORD_W(WORD_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wordIn(wordIn),
    .memRdata(memRdata), .memAddr(memAddr), .respWord(respWord)
  );

  // R5: request, address and size hold until termination
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !memErr) |=> memReq && $stable(memAddr) && $stable(memSize));

  // R5: request drops after termination
  a_r5_req_drop: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && (memAck || memErr)) |=> !memReq);

  // R6: not-ready is presented throughout an outstanding access
  a_r6_busy_notready: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (respWord == {1'b1, {WORD_W{1'b0}}}));

  // R4: a request only starts right after a received word
  a_r4_req_after_word: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) |-> $past(wordValid));

  // R9: bus error yields the error status
  a_r9_berr_status: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memErr) |=> (respWord == {1'b1, WORD_W'(1)}));

  // R7: longword high half is returned first
  a_r7_long_high: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && !memErr && memSize == SZ_LONG) |=>
      (respWord == {1'b0, $past(memRdata[2*WORD_W-1 -: WORD_W])}));

endmodule

// File: tb/sim_dbg_cmd_seq.sv
`timescale 1ns/1ps
module sim_dbg_cmd_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wordValid = 1'b0;
  logic [15:0] wordIn = '0;
  logic [16:0] respWord;
  logic        memReq;
  logic [31:0] memAddr;
  logic [1:0]  memSize;
  logic        memAck = 1'b0;
  logic        memErr = 1'b0;
  logic [31:0] memRdata = '0;

  always #2 clk = ~clk;

  dbg_cmd_seq u0 (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordIn(wordIn),
    .respWord(respWord), .memReq(memReq), .memAddr(memAddr),
    .memSize(memSize), .memAck(memAck), .memErr(memErr), .memRdata(memRdata)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [16:0] NR   = {1'b1, 16'h0000};
  localparam logic [16:0] FLAG = {1'b1, 16'hFFFF};
  localparam logic [16:0] BERR = {1'b1, 16'h0001};

  // expectation for the next command's first transfer
  logic [16:0] pendExp;
  bit          pendByte;
  string       pendTag;

  // memory responder settings
  int          lat = 0;
  bit          errOn = 1'b0;
  logic [31:0] expAddr;
  logic [1:0]  expSize;
  int          waitCnt = 0;

  function automatic logic [31:0] model(input logic [31:0] a);
    return a * 32'd2654435761 + 32'd12345;
  endfunction

  task automatic check(input string tag, input logic [16:0] got,
                       input logic [16:0] exp, input bit byteOnly);
    bit ok;
    checks++;
    ok = byteOnly ? (got[16] == exp[16] && got[7:0] == exp[7:0]) : (got == exp);
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%05h expected=%05h", tag, got, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] w, output logic [16:0] r);
    @(negedge clk);
    r = respWord;
    wordValid = 1'b1;
    wordIn = w;
    @(negedge clk);
    wordValid = 1'b0;
    // R10: next response must already be in place here
  endtask

  initial begin : responder
    forever begin
      @(negedge clk);
      memAck = 1'b0;
      memErr = 1'b0;
      if (memReq) begin
        if (waitCnt == lat) begin
          checks++;
          if (memAddr !== expAddr || memSize !== expSize) begin
            failures++;
            $display("FAIL R6 addr/size at termination actual=%08h/%0d expected=%08h/%0d",
                     memAddr, memSize, expAddr, expSize);
          end
          memRdata = model(memAddr);
          if (errOn) memErr = 1'b1; else memAck = 1'b1;
          waitCnt = 0;
        end else begin
          waitCnt++;
        end
      end
    end
  end

  task automatic doRead(input logic [1:0] sz, input logic [31:0] a,
                        input int l, input bit e);
    logic [16:0] r;
    logic [31:0] d;
    int guard;
    lat = l; errOn = e; expAddr = a; expSize = sz;
    xfer({8'hA5, 6'd0, sz}, r);
    check({pendTag, " previous result"}, r, pendExp, pendByte);
    xfer(a[31:16], r);
    check("R4 opcode reply", r, NR, 1'b0);
    xfer(a[15:0], r);
    check("R4 addr-hi reply", r, NR, 1'b0);
    // memReq was raised at the posedge before this sample
    checks++;
    if (!(memReq === 1'b1 && memAddr === a && memSize === sz)) begin
      failures++;
      $display("FAIL R4 request actual=%0b/%08h/%0d expected=1/%08h/%0d",
               memReq, memAddr, memSize, a, sz);
    end
    if (l >= 3) begin
      xfer(16'hA502, r);
      check("R6 poll during access", r, NR, 1'b0);
    end
    guard = 0;
    while (memReq && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    d = model(a);
    pendByte = 1'b0;
    if (e) begin
      pendExp = BERR; pendTag = "R9";
    end else if (sz == 2'd2) begin
      xfer(16'h0000, r);
      check("R7 high half", r, {1'b0, d[31:16]}, 1'b0);
      pendExp = {1'b0, d[15:0]}; pendTag = "R7";
    end else if (sz == 2'd1) begin
      pendExp = {1'b0, d[15:0]}; pendTag = "R8";
    end else begin
      pendExp = {9'd0, d[7:0]}; pendByte = 1'b1; pendTag = "R8";
    end
  endtask

  task automatic doIllegal(input logic [15:0] op);
    logic [16:0] r;
    xfer(op, r);
    check({pendTag, " previous result"}, r, pendExp, pendByte);
    xfer(16'hA502, r);   // legal opcode, must be discarded
    check("R2 illegal status", r, FLAG, 1'b0);
    pendExp = FLAG; pendByte = 1'b0; pendTag = "R3";
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] a;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset response", respWord, FLAG, 1'b0);
    checks++;
    if (memReq !== 1'b0) begin
      failures++;
      $display("FAIL R1 memReq actual=%b expected=0", memReq);
    end
    pendExp = FLAG; pendByte = 1'b0; pendTag = "R1";

    for (int s = 0; s < 3; s++) begin
      for (int l = 0; l < 5; l++) begin
        for (int k = 0; k < 4; k++) begin
          a = (32'h1357_9BDF * (s * 20 + l * 4 + k + 1)) ^ 32'hA5A5_0F0F;
          doRead(s[1:0], a, l, k == 3);
        end
      end
      doIllegal(16'hA503);
    end
    doIllegal(16'h0000);
    doIllegal(16'hA504);
    doIllegal(16'hA480);
    doIllegal(16'hFFFF);
    doRead(2'd2, 32'hFFFF_0000, 4, 1'b0);
    doIllegal(16'h25A5);
    doRead(2'd0, 32'h0000_FFFF, 0, 1'b0);
    doRead(2'd1, 32'h8000_0001, 0, 1'b1);
    doRead(2'd1, 32'h0000_0000, 1, 1'b0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule